// File: doc/BRIEF.md
# Second-Order Incremental Sigma-Delta Optimal Decoder

This block decodes the ±1 bit stream of a second-order incremental sigma-delta modulator whose integrators are cleared before each conversion. It keeps a lower and an upper bound on the constant input value. For every incoming bit it rebuilds the threshold that the modulator compared the input against. Bits from sample 3 onward tighten one of the two bounds. After the last bit of the conversion, the midpoint of the surviving interval is the estimate with the least mean square error.

All values are exact rationals, each a signed numerator over a positive denominator. No division is performed. The threshold at sample n uses a triangularly weighted predictor that is updated incrementally, so no per-sample multiply is needed. Comparisons against the bounds are done by cross-multiplication. A conversion begins with a start pulse that carries the number of bits m. Bits then arrive one per cycle or with idle cycles between them. A one-cycle done pulse marks the point where the bounds and the estimate are final.

Top module: `sd2_opt_decoder`

## Requirements
- R1: After reset, done_o is 0, the lower bound is −1/1, the upper bound is 1/1, and the estimate is 0/2.
- R2: A start_i pulse loads len_i as m, returns both bounds to −1/1 and 1/1, and restarts sample counting at 1. This holds even in the middle of a conversion. A len_i of 0 starts no conversion.
- R3: On bit_i, 1 encodes +1 and 0 encodes −1. The threshold at sample n is 2·P(n)/(n·(n−1)), with P(n) = Σ_{i<n} (n−i+1)·b(i).
- R4: The predictor P(n) is odd exactly when n mod 4 is 0 or 3.
- R5: From sample 3 on, a +1 bit replaces the lower bound with the threshold only if the threshold is strictly greater, and a −1 bit replaces the upper bound only if the threshold is strictly smaller. A replaced bound is reported as numerator 2·P(n) and denominator n·(n−1), unreduced, and its denominator is never 0.
- R6: Samples 1 and 2 never change either bound.
- R7: done_o is high for exactly one cycle: the cycle after the clock edge that accepts bit m.
- R8: The estimate numerator is ub_num·lb_den + lb_num·ub_den and the estimate denominator is 2·ub_den·lb_den.
- R9: The bounds ignore a bit when bit_valid_i is low, when no conversion has been started, or when it arrives after bit m.
- R10: For a stream produced by the modulator from an input x in (−1, 1), the final bounds satisfy LB ≤ x < UB, with LB < UB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion; clears bounds and counters |
| len_i | input | LEN_W | Bits per conversion (m), sampled on start_i |
| bit_valid_i | input | 1 | bit_i carries a modulator bit this cycle |
| bit_i | input | 1 | Modulator bit: 1 = +1, 0 = −1 |
| done_o | output | 1 | One-cycle pulse: bounds and estimate are final |
| lb_num_o | output | 2·LEN_W+1 | Lower bound numerator (signed) |
| lb_den_o | output | 2·LEN_W | Lower bound denominator |
| ub_num_o | output | 2·LEN_W+1 | Upper bound numerator (signed) |
| ub_den_o | output | 2·LEN_W | Upper bound denominator |
| est_num_o | output | 4·LEN_W+2 | Estimate numerator (signed) |
| est_den_o | output | 4·LEN_W+1 | Estimate denominator |

## Verification
A bit is registered into the bounds on the clock edge that accepts it. The bounds are therefore valid one edge later, and the estimate follows them combinationally in the same cycle. done_o rises in that same cycle after bit m and falls on the next edge. The bench drives inputs on falling edges and reads results on the falling edge right after the accepting edge, which is the only cycle in which done_o is high. It then checks on the next falling edge that done_o has dropped. The expected bounds come from a bench model of the modulator and decoder that sums the predictor directly rather than incrementally.

// File: rtl/sd2_pkg.sv
package sd2_pkg;
  typedef enum logic {SYM_NEG = 1'b0, SYM_POS = 1'b1} sym_e;
  // samples 1 and 2 are fixed by the modulator's zero start state
  localparam int unsigned FIRST_LIVE_SAMPLE = 3;
endpackage

// File: rtl/sd2_predictor.sv
module sd2_predictor #(
  parameter int unsigned LEN_W = 8,
  localparam int unsigned CNT_W = LEN_W + 1,
  localparam int unsigned DEN_W = 2 * LEN_W,
  localparam int unsigned NUM_W = DEN_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  sd2_pkg::sym_e           sym_i,
  output logic [CNT_W-1:0]        n_o,
  output logic signed [NUM_W-1:0] t_num_o,
  output logic [DEN_W-1:0]        t_den_o
);
  localparam logic signed [NUM_W-1:0] TWO_S = 2;
  localparam logic signed [CNT_W-1:0] ONE_S = 1;

  logic [CNT_W-1:0]        n_q;
  logic signed [NUM_W-1:0] p_q;   // P(n)
  logic signed [CNT_W-1:0] s_q;   // S(n-1)
  logic [DEN_W-1:0]        d_q;   // n(n-1)

  logic signed [NUM_W-1:0] s_ext, p_inc;
  logic signed [CNT_W-1:0] s_inc;

  always_comb begin
    s_ext = {{(NUM_W-CNT_W){s_q[CNT_W-1]}}, s_q};
    p_inc = (sym_i == sd2_pkg::SYM_POS) ? TWO_S : -TWO_S;
    s_inc = (sym_i == sd2_pkg::SYM_POS) ? ONE_S : -ONE_S;
  end

  // P(n+1) = P(n) + S(n-1) + 2 b(n); n(n-1) grows by 2n
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= CNT_W'(1);
      p_q <= '0;
      s_q <= '0;
      d_q <= '0;
    end else if (clear_i) begin
      n_q <= CNT_W'(1);
      p_q <= '0;
      s_q <= '0;
      d_q <= '0;
    end else if (step_i) begin
      n_q <= n_q + CNT_W'(1);
      p_q <= p_q + s_ext + p_inc;
      s_q <= s_q + s_inc;
      d_q <= d_q + DEN_W'({n_q, 1'b0});
    end
  end

  assign n_o     = n_q;
  assign t_num_o = p_q <<< 1;
  assign t_den_o = d_q;

  // predictor takes every other integer: odd iff n mod 4 is 0 or 3
  assert_pred_parity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_q[0] == (n_q[1] ~^ n_q[0]))
    else $error("predictor parity broken");
endmodule

// File: rtl/sd2_bound_step.sv
module sd2_bound_step #(
  parameter int unsigned NUM_W = 17,
  parameter int unsigned DEN_W = 16,
  parameter bit          LOWER = 1'b1,
  localparam int unsigned PW = NUM_W + DEN_W + 1
) (
  input  logic                    en_i,
  input  logic signed [NUM_W-1:0] t_num_i,
  input  logic [DEN_W-1:0]        t_den_i,
  input  logic signed [NUM_W-1:0] cur_num_i,
  input  logic [DEN_W-1:0]        cur_den_i,
  output logic signed [NUM_W-1:0] nxt_num_o,
  output logic [DEN_W-1:0]        nxt_den_o
);
  logic signed [PW-1:0] lhs, rhs;
  logic                 tighter;

  // denominators are positive, so the cross products keep the order
  always_comb begin
    lhs = PW'(t_num_i) * $signed(PW'(cur_den_i));
    rhs = PW'(cur_num_i) * $signed(PW'(t_den_i));
  end

  generate
    if (LOWER) begin : g_lower
      assign tighter = lhs > rhs;
    end else begin : g_upper
      assign tighter = lhs < rhs;
    end
  endgenerate

  assign nxt_num_o = (en_i && tighter) ? t_num_i : cur_num_i;
  assign nxt_den_o = (en_i && tighter) ? t_den_i : cur_den_i;
endmodule

// File: rtl/sd2_midpoint.sv
module sd2_midpoint #(
  parameter int unsigned NUM_W = 17,
  parameter int unsigned DEN_W = 16,
  localparam int unsigned EN_W = NUM_W + DEN_W + 1,
  localparam int unsigned ED_W = 2 * DEN_W + 1
) (
  input  logic signed [NUM_W-1:0] lb_num_i,
  input  logic [DEN_W-1:0]        lb_den_i,
  input  logic signed [NUM_W-1:0] ub_num_i,
  input  logic [DEN_W-1:0]        ub_den_i,
  output logic signed [EN_W-1:0]  est_num_o,
  output logic [ED_W-1:0]         est_den_o
);
  logic signed [EN_W-1:0] ub_part, lb_part;

  always_comb begin
    ub_part   = EN_W'(ub_num_i) * $signed(EN_W'(lb_den_i));
    lb_part   = EN_W'(lb_num_i) * $signed(EN_W'(ub_den_i));
    est_num_o = ub_part + lb_part;
    est_den_o = ED_W'({ub_den_i, 1'b0}) * ED_W'(lb_den_i);
  end
endmodule

// File: rtl/sd2_opt_decoder.sv
module sd2_opt_decoder #(
  parameter int unsigned LEN_W = 8,
  localparam int unsigned CNT_W = LEN_W + 1,
  localparam int unsigned DEN_W = 2 * LEN_W,
  localparam int unsigned NUM_W = DEN_W + 1,
  localparam int unsigned EN_W  = NUM_W + DEN_W + 1,
  localparam int unsigned ED_W  = 2 * DEN_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    bit_valid_i,
  input  logic                    bit_i,
  output logic                    done_o,
  output logic signed [NUM_W-1:0] lb_num_o,
  output logic [DEN_W-1:0]        lb_den_o,
  output logic signed [NUM_W-1:0] ub_num_o,
  output logic [DEN_W-1:0]        ub_den_o,
  output logic signed [EN_W-1:0]  est_num_o,
  output logic [ED_W-1:0]         est_den_o
);
  import sd2_pkg::*;

  localparam logic signed [NUM_W-1:0] NEG_ONE = -1;
  localparam logic signed [NUM_W-1:0] POS_ONE = 1;
  localparam logic [DEN_W-1:0]        UNIT    = 1;

  logic                    active_q, done_q;
  logic [LEN_W-1:0]        len_q;
  logic signed [NUM_W-1:0] lb_num_q, ub_num_q, lb_num_d, ub_num_d;
  logic [DEN_W-1:0]        lb_den_q, ub_den_q, lb_den_d, ub_den_d;

  logic                    step, live, last;
  sym_e                    sym;
  logic [CNT_W-1:0]        n;
  logic signed [NUM_W-1:0] t_num;
  logic [DEN_W-1:0]        t_den;

  assign sym  = sym_e'(bit_i);
  assign step = bit_valid_i && active_q && !start_i;
  assign live = n >= CNT_W'(FIRST_LIVE_SAMPLE);
  assign last = step && (n == {1'b0, len_q});

  sd2_predictor #(.LEN_W(LEN_W)) u_pred (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .step_i  (step),
    .sym_i   (sym),
    .n_o     (n),
    .t_num_o (t_num),
    .t_den_o (t_den)
  );

  sd2_bound_step #(.NUM_W(NUM_W), .DEN_W(DEN_W), .LOWER(1'b1)) u_lb (
    .en_i      (step && live && sym == SYM_POS),
    .t_num_i   (t_num),
    .t_den_i   (t_den),
    .cur_num_i (lb_num_q),
    .cur_den_i (lb_den_q),
    .nxt_num_o (lb_num_d),
    .nxt_den_o (lb_den_d)
  );

  sd2_bound_step #(.NUM_W(NUM_W), .DEN_W(DEN_W), .LOWER(1'b0)) u_ub (
    .en_i      (step && live && sym == SYM_NEG),
    .t_num_i   (t_num),
    .t_den_i   (t_den),
    .cur_num_i (ub_num_q),
    .cur_den_i (ub_den_q),
    .nxt_num_o (ub_num_d),
    .nxt_den_o (ub_den_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      len_q    <= '0;
      lb_num_q <= NEG_ONE;
      lb_den_q <= UNIT;
      ub_num_q <= POS_ONE;
      ub_den_q <= UNIT;
    end else if (start_i) begin
      active_q <= len_i != '0;
      done_q   <= 1'b0;
      len_q    <= len_i;
      lb_num_q <= NEG_ONE;
      lb_den_q <= UNIT;
      ub_num_q <= POS_ONE;
      ub_den_q <= UNIT;
    end else begin
      done_q <= last;
      if (last) active_q <= 1'b0;
      if (step) begin
        lb_num_q <= lb_num_d;
        lb_den_q <= lb_den_d;
        ub_num_q <= ub_num_d;
        ub_den_q <= ub_den_d;
      end
    end
  end

  sd2_midpoint #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_mid (
    .lb_num_i  (lb_num_q),
    .lb_den_i  (lb_den_q),
    .ub_num_i  (ub_num_q),
    .ub_den_i  (ub_den_q),
    .est_num_o (est_num_o),
    .est_den_o (est_den_o)
  );

  assign done_o   = done_q;
  assign lb_num_o = lb_num_q;
  assign lb_den_o = lb_den_q;
  assign ub_num_o = ub_num_q;
  assign ub_den_o = ub_den_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q)
    else $error("done held longer than one cycle");

  assert_fixed_samples_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !live) |=> ($stable(lb_num_q) && $stable(lb_den_q) &&
                         $stable(ub_num_q) && $stable(ub_den_q)))
    else $error("bound moved on sample 1 or 2");

  assert_idle_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start_i) |=> ($stable(lb_num_q) && $stable(lb_den_q) &&
                                 $stable(ub_num_q) && $stable(ub_den_q)))
    else $error("bound moved while idle");

  assert_den_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_den_q != '0) && (ub_den_q != '0))
    else $error("zero bound denominator");
endmodule

// File: tb/sd2_opt_decoder_tb_top.sv
module sd2_opt_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int DEN_W = 2 * LEN_W;
  localparam int NUM_W = DEN_W + 1;
  localparam int EN_W  = NUM_W + DEN_W + 1;
  localparam int ED_W  = 2 * DEN_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic done;
  logic signed [NUM_W-1:0] lb_num, ub_num;
  logic [DEN_W-1:0] lb_den, ub_den;
  logic signed [EN_W-1:0] est_num;
  logic [ED_W-1:0] est_den;

  int checks = 0, failures = 0;
  int mb [1:256];
  longint e_lbn, e_lbd, e_ubn, e_ubd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd2_opt_decoder #(.LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .bit_valid_i(bit_valid), .bit_i(bit_in), .done_o(done),
    .lb_num_o(lb_num), .lb_den_o(lb_den), .ub_num_o(ub_num), .ub_den_o(ub_den),
    .est_num_o(est_num), .est_den_o(est_den)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  // modulator via its effective comparison, decoder with directly summed predictor
  task automatic model(input longint xn, input longint xd, input int m);
    e_lbn = -1; e_lbd = 1; e_ubn = 1; e_ubd = 1;
    for (int n = 1; n <= m; n++) begin
      longint p = 0;
      longint d = longint'(n) * (n - 1);
      for (int i = 1; i < n; i++) p += longint'(n - i + 1) * mb[i];
      mb[n] = (xn * d >= 2 * p * xd) ? 1 : -1;
      if (n >= 3) begin
        if (mb[n] > 0 && 2 * p * e_lbd > e_lbn * d) begin e_lbn = 2 * p; e_lbd = d; end
        if (mb[n] < 0 && 2 * p * e_ubd < e_ubn * d) begin e_ubn = 2 * p; e_ubd = d; end
      end
    end
  endtask

  task automatic do_start(input int m);
    @(negedge clk); start = 1'b1; len = LEN_W'(m);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_bits(input int first, input int last_k, input bit gap);
    for (int k = first; k <= last_k; k++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = (mb[k] > 0);
      if (gap) begin @(negedge clk); bit_valid = 1'b0; bit_in = ~bit_in; end
    end
    if (!gap) begin @(negedge clk); bit_valid = 1'b0; end
  endtask

  task automatic check_bounds(input string tag);
    chk_eq({tag, " R3/R5 lb_num"}, longint'(lb_num), e_lbn);
    chk_eq({tag, " R3/R5 lb_den"}, longint'(lb_den), e_lbd);
    chk_eq({tag, " R3/R5 ub_num"}, longint'(ub_num), e_ubn);
    chk_eq({tag, " R3/R5 ub_den"}, longint'(ub_den), e_ubd);
    chk_eq({tag, " R8 est_num"}, longint'(est_num), e_ubn * e_lbd + e_lbn * e_ubd);
    chk_eq({tag, " R8 est_den"}, longint'(est_den), 2 * e_ubd * e_lbd);
  endtask

  // sampled on the falling edge right after bit m is accepted
  task automatic check_final(input longint xn, input longint xd, input string tag);
    chk_eq({tag, " R7 done high"}, longint'(done), 1);
    check_bounds(tag);
    chk(xn * longint'(lb_den) >= longint'(lb_num) * xd, {tag, " R10 x>=LB"},
        longint'(lb_num), xn);
    chk(xn * longint'(ub_den) < longint'(ub_num) * xd, {tag, " R10 x<UB"},
        longint'(ub_num), xn);
    chk(longint'(lb_num) * longint'(ub_den) < longint'(ub_num) * longint'(lb_den),
        {tag, " R10 LB<UB"}, longint'(lb_num), longint'(ub_num));
    @(negedge clk);
    chk_eq({tag, " R7 done drops"}, longint'(done), 0);
  endtask

  task automatic run_conv(input longint xn, input longint xd, input int m,
                          input bit gap, input string tag);
    model(xn, xd, m);
    do_start(m);
    send_bits(1, m, gap);
    check_final(xn, xd, tag);
  endtask

  task automatic test_reset;
    chk_eq("R1 done", longint'(done), 0);
    chk_eq("R1 lb_num", longint'(lb_num), -1);
    chk_eq("R1 lb_den", longint'(lb_den), 1);
    chk_eq("R1 ub_num", longint'(ub_num), 1);
    chk_eq("R1 ub_den", longint'(ub_den), 1);
    chk_eq("R1 est_num", longint'(est_num), 0);
    chk_eq("R1 est_den", longint'(est_den), 2);
  endtask

  task automatic test_three;
    // x = 1/2: bits +1,-1,+1; P(3)=1, threshold 2/6 raises LB
    run_conv(1, 2, 3, 1'b0, "three");
    chk_eq("three R5 lb_num hand", e_lbn, 2);
    chk_eq("three R5 lb_den hand", e_lbd, 6);
    chk_eq("three R4 odd P(3)", e_lbn / 2 % 2 == 0 ? 0 : 1, 1);
  endtask

  task automatic test_short;
    run_conv(-3, 10, 2, 1'b0, "short");
    chk_eq("short R6 lb_num", longint'(lb_num), -1);
    chk_eq("short R6 ub_num", longint'(ub_num), 1);
  endtask

  task automatic test_sweep;
    run_conv(1, 3, 16, 1'b0, "sweep a");
    run_conv(-7, 10, 24, 1'b0, "sweep b");
    run_conv(5, 9, 64, 1'b1, "sweep c gaps");
    run_conv(-1, 200, 100, 1'b0, "sweep d");
    run_conv(99, 100, 255, 1'b0, "sweep e");
    run_conv(-4, 5, 40, 1'b1, "sweep f gaps");
  endtask

  task automatic test_ignore;
    longint ln, ld, un, ud;
    // after done: further bits must not move anything
    run_conv(2, 7, 12, 1'b0, "ign base");
    ln = lb_num; ld = lb_den; un = ub_num; ud = ub_den;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = k[0];
    end
    @(negedge clk); bit_valid = 1'b0;
    chk_eq("R9 post lb_num", longint'(lb_num), ln);
    chk_eq("R9 post lb_den", longint'(lb_den), ld);
    chk_eq("R9 post ub_num", longint'(ub_num), un);
    chk_eq("R9 post ub_den", longint'(ub_den), ud);
    chk_eq("R9 post no done", longint'(done), 0);
    // zero length starts nothing
    do_start(0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
    end
    @(negedge clk); bit_valid = 1'b0;
    chk_eq("R2 len0 lb_num", longint'(lb_num), -1);
    chk_eq("R2 len0 ub_num", longint'(ub_num), 1);
    chk_eq("R2 len0 no done", longint'(done), 0);
  endtask

  task automatic test_restart;
    model(1, 3, 20);
    do_start(20);
    send_bits(1, 10, 1'b0);
    chk(longint'(lb_num) != -1 || longint'(ub_num) != 1, "R2 pre-restart moved",
        longint'(lb_num), -1);
    run_conv(-1, 2, 12, 1'b0, "R2 restart");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    @(negedge clk);
    // bits before any start are ignored
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
    end
    @(negedge clk); bit_valid = 1'b0;
    chk_eq("R9 pre-start lb_num", longint'(lb_num), -1);
    chk_eq("R9 pre-start no done", longint'(done), 0);
    test_three;
    test_short;
    test_sweep;
    test_ignore;
    test_restart;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule